// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a two-port byte store in which both sides can access any location independently, in the same clock. The two highest addresses also serve as message slots between the two sides. When the left side writes the top slot, an active-low interrupt is raised toward the right side. It stays raised until the right side reads that slot. The slot just below the top works the same way in the other direction: a right-side write raises an interrupt toward the left side, and a left-side read clears it.

Each side has an active-low select, a write strobe (low means write), an active-low read enable, an address, write data and registered read data. Accesses are synchronous to one clock. A write takes effect at the clock edge. A read shows the byte that was stored before that edge on the read data output from the next cycle onward, and that output then holds until the next read. The message bytes are ordinary storage locations, so the sender and the receiver can both read and rewrite them freely.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: After reset, both interrupt outputs are high (inactive) and both read data outputs are zero.
- R2: A write (select low, write strobe low) stores the byte at the address at the clock edge. A read (select low, write strobe high, read enable low) places the stored byte on that side's read data output in the following cycle. The output holds its value when no read is made.
- R3: A completed left write to the top address (all address bits one, 0x7FF by default) drives the right interrupt low from the next cycle. It stays low until cleared.
- R4: A right read of the top address drives the right interrupt high again from the next cycle.
- R5: A completed right write to the address one below the top (0x7FE by default) drives the left interrupt low from the next cycle. It stays low until cleared.
- R6: A left read of the address one below the top drives the left interrupt high again from the next cycle.
- R7: If a flag is set and cleared in the same cycle, the flag ends up set (interrupt low).
- R8: No other access changes either interrupt. This covers a side writing its own incoming slot, a side reading its own outgoing slot, a read made with the read enable high, and any access made with the select high.
- R9: If one side writes an address in the same cycle that the other side reads it, the reader receives the byte held before that write.
- R10: The message slots keep the last byte written to them by either side, and a read of a slot returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, low = write |
| l_oe_n | input | 1 | Left read enable, active low |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_irq_n | output | 1 | Interrupt toward the left side, active low |
| r_ce_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, low = write |
| r_oe_n | input | 1 | Right read enable, active low |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_irq_n | output | 1 | Interrupt toward the right side, active low |

## Verification
Plain storage is tested with several data patterns written from each side and read back from the other, so that a crossed port or a dropped write shows up. Each slot then goes through a full message exchange. Around the exchange are near-miss accesses: the sender reading its own slot, the receiver writing it, a read with the read enable high, and an unselected write. These separate the real set and clear conditions from looser decodes. Same-cycle write and read of a slot tells the set-wins priority apart from clear-wins. It also shows whether the read returns the byte from before or after the write.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  // A completed write needs both the select and the write strobe low.
  function automatic logic f_write(input logic ce_n, input logic we_n);
    return !ce_n && !we_n;
  endfunction

  // A read needs the select and read enable low with the strobe high.
  function automatic logic f_read(input logic ce_n, input logic we_n, input logic oe_n);
    return !ce_n && we_n && !oe_n;
  endfunction
endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec #(
  parameter int AW = 11,
  parameter logic [AW-1:0] OUT_SLOT = '1,
  parameter logic [AW-1:0] IN_SLOT  = '0
) (
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic          post_ev,
  output logic          take_ev
);
  import dpmb_pkg::*;

  assign wr_ev   = f_write(ce_n, we_n);
  assign rd_ev   = f_read(ce_n, we_n, oe_n);
  // Posting: a write to this side's outgoing slot.
  assign post_ev = wr_ev && (addr == OUT_SLOT);
  // Taking: a read of this side's incoming slot.
  assign take_ev = rd_ev && (addr == IN_SLOT);
endmodule

// File: rtl/dpmb_store.sv
module dpmb_store #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          wr_ev,
  input  logic [NP-1:0]          rd_ev,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [NP-1:0][DW-1:0]  wdata,
  output logic [NP-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rq  [NP];

  // Higher-numbered ports are applied last on a same-address write.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (wr_ev[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rq[p] <= '0;
      else if (rd_ev[p]) rq[p] <= mem[addr[p]];
    end
    assign rdata[p] = rq[p];
  end

  // R2: a byte written by port 0 is seen by port 1 reading it one cycle later
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev[1] && $past(wr_ev[0]) && ($past(addr[0]) == addr[1]) &&
     !($past(wr_ev[1]) && ($past(addr[1]) == addr[1])))
    |=> (rdata[1] == $past(wdata[0], 2)));
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  // Set has priority over clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(flag));
endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_ce_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] SLOT_TO_R = '1;                  // left posts here
  localparam logic [AW-1:0] SLOT_TO_L = SLOT_TO_R - 1'b1;    // right posts here

  logic l_wr, l_rd, l_post, l_take;
  logic r_wr, r_rd, r_post, r_take;
  logic flag_l, flag_r;
  logic [1:0][DW-1:0] rdata_w;

  dpmb_port_dec #(.AW(AW), .OUT_SLOT(SLOT_TO_R), .IN_SLOT(SLOT_TO_L)) u_dec_l (
    .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n), .addr(l_addr),
    .wr_ev(l_wr), .rd_ev(l_rd), .post_ev(l_post), .take_ev(l_take));

  dpmb_port_dec #(.AW(AW), .OUT_SLOT(SLOT_TO_L), .IN_SLOT(SLOT_TO_R)) u_dec_r (
    .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n), .addr(r_addr),
    .wr_ev(r_wr), .rd_ev(r_rd), .post_ev(r_post), .take_ev(r_take));

  dpmb_store #(.AW(AW), .DW(DW), .NP(2)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_ev({r_wr, l_wr}), .rd_ev({r_rd, l_rd}),
    .addr({r_addr, l_addr}), .wdata({r_wdata, l_wdata}),
    .rdata(rdata_w));

  // Flag toward the right side: set by a left post, cleared by a right take.
  dpmb_flag u_flag_r (.clk(clk), .rst_n(rst_n),
    .set_ev(l_post), .clr_ev(r_take), .flag(flag_r));
  // Flag toward the left side: set by a right post, cleared by a left take.
  dpmb_flag u_flag_l (.clk(clk), .rst_n(rst_n),
    .set_ev(r_post), .clr_ev(l_take), .flag(flag_l));

  assign l_rdata = rdata_w[0];
  assign r_rdata = rdata_w[1];
  assign l_irq_n = !flag_l;
  assign r_irq_n = !flag_r;

  // R3
  post_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_we_n && (l_addr == SLOT_TO_R)) |=> !r_irq_n);

  // R5
  post_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_we_n && (r_addr == SLOT_TO_L)) |=> !l_irq_n);
endmodule

// File: tb/test_dual_port_mailbox_ram.sv
`timescale 1ns/1ps
module test_dual_port_mailbox_ram;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP  = 11'h7FF;
  localparam logic [AW-1:0] NEXT = 11'h7FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1, l_we_n = 1, l_oe_n = 1;
  logic r_ce_n = 1, r_we_n = 1, r_oe_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #2.5 clk = ~clk;

  dual_port_mailbox_ram #(.AW(AW), .DW(DW)) i_dual_port_mailbox_ram (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [7:0]  rl, rr;
    logic        il, ir;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // Model state, written from the requirements.
  logic [7:0] shm [int];
  logic [7:0] m_rl = 0, m_rr = 0;
  logic m_fl = 0, m_fr = 0;

  task automatic chk(input string what, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces them.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      chk("l_rdata", e.tag, l_rdata, e.rl);
      chk("r_rdata", e.tag, r_rdata, e.rr);
      chk("l_irq_n", e.tag, {7'd0, l_irq_n}, {7'd0, e.il});
      chk("r_irq_n", e.tag, {7'd0, r_irq_n}, {7'd0, e.ir});
    end
  end

  function automatic logic [7:0] mread(input logic [AW-1:0] a);
    return shm.exists(int'(a)) ? shm[int'(a)] : 8'h00;
  endfunction

  // Driver: one cycle of stimulus on both sides plus its expectation.
  task automatic acc(input logic lce, input logic lwe, input logic loe,
                     input logic [AW-1:0] la, input logic [7:0] ld,
                     input logic rce, input logic rwe, input logic roe,
                     input logic [AW-1:0] ra, input logic [7:0] rd,
                     input string tag);
    logic rdl, wrl, rdr, wrr;
    exp_t it;
    @(posedge clk); #1;
    l_ce_n = lce; l_we_n = lwe; l_oe_n = loe; l_addr = la; l_wdata = ld;
    r_ce_n = rce; r_we_n = rwe; r_oe_n = roe; r_addr = ra; r_wdata = rd;
    rdl = !lce && lwe && !loe;  wrl = !lce && !lwe;
    rdr = !rce && rwe && !roe;  wrr = !rce && !rwe;
    if (rdl) m_rl = mread(la);
    if (rdr) m_rr = mread(ra);
    if (rdr && ra == TOP)  m_fr = 0;
    if (wrl && la == TOP)  m_fr = 1;
    if (rdl && la == NEXT) m_fl = 0;
    if (wrr && ra == NEXT) m_fl = 1;
    if (wrl) shm[int'(la)] = ld;
    if (wrr) shm[int'(ra)] = rd;
    it.due = cyc + 1; it.rl = m_rl; it.rr = m_rr;
    it.il = !m_fl; it.ir = !m_fr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic lwr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    acc(0, 0, 1, a, d, 1, 1, 1, '0, '0, tag);
  endtask
  task automatic lrd(input logic [AW-1:0] a, input string tag);
    acc(0, 1, 0, a, '0, 1, 1, 1, '0, '0, tag);
  endtask
  task automatic rwr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    acc(1, 1, 1, '0, '0, 0, 0, 1, a, d, tag);
  endtask
  task automatic rrd(input logic [AW-1:0] a, input string tag);
    acc(1, 1, 1, '0, '0, 0, 1, 0, a, '0, tag);
  endtask
  task automatic idle(input string tag);
    acc(1, 1, 1, '0, '0, 1, 1, 1, '0, '0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("l_rdata", "R1", l_rdata, 8'h00);
    chk("r_rdata", "R1", r_rdata, 8'h00);
    chk("l_irq_n", "R1", {7'd0, l_irq_n}, 8'h01);
    chk("r_irq_n", "R1", {7'd0, r_irq_n}, 8'h01);

    // R2: storage with several patterns, crossed between the sides
    for (int i = 0; i < 8; i++) lwr(11'(i * 37), 8'(i * 29 + 1), "R2");
    for (int i = 0; i < 8; i++) rrd(11'(i * 37), "R2");
    rwr(11'h100, 8'hFF, "R2");
    rwr(11'h101, 8'h00, "R2");
    rwr(11'h102, 8'hA5, "R2");
    lrd(11'h100, "R2"); lrd(11'h101, "R2"); lrd(11'h102, "R2");
    idle("R2");

    // R9: same-cycle write by left and read by right of one address
    acc(0, 0, 1, 11'h102, 8'h5A, 0, 1, 0, 11'h102, 8'h00, "R9");
    rrd(11'h102, "R9");

    // Right-bound slot exchange with near misses
    rwr(TOP, 8'h77, "R8");                       // own incoming slot
    lwr(TOP, 8'h3C, "R3");
    idle("R3");
    lrd(TOP, "R8");                              // own outgoing slot
    acc(1, 1, 1, '0, '0, 0, 1, 1, TOP, '0, "R8"); // read enable high
    rrd(TOP, "R4");
    rrd(TOP, "R10");

    // Left-bound slot exchange with near misses
    lwr(NEXT, 8'h11, "R8");
    rwr(NEXT, 8'hC3, "R5");
    idle("R5");
    rrd(NEXT, "R8");
    acc(0, 1, 1, NEXT, '0, 1, 1, 1, '0, '0, "R8");
    acc(1, 0, 1, NEXT, 8'h99, 1, 0, 1, TOP, 8'h99, "R8"); // unselected writes
    lrd(NEXT, "R6");
    lrd(NEXT, "R10");
    acc(1, 0, 1, TOP, 8'h44, 1, 1, 1, '0, '0, "R8");

    // R7: set and clear in one cycle, both directions
    acc(0, 0, 1, TOP, 8'h81, 0, 1, 0, TOP, '0, "R7");
    idle("R7");
    rrd(TOP, "R4");
    acc(0, 1, 0, NEXT, '0, 0, 0, 1, NEXT, 8'h42, "R7");
    idle("R7");
    lrd(NEXT, "R6");
    idle("R10");

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule